// File: doc/BRIEF.md
# Platform Reset Pulse Generator

This block produces the two reset pulses a board controller uses to restart a host platform. A cold request briefly pulls the power-good line seen by the platform controller low, then lets it follow the sequencer again. The controller treats this as a full power cycle of the rest of the system. A warm request lowers an active-low CPU-init request line for a short time and leaves every power signal alone.

Pulse widths are counted in ticks of a free-running microsecond strobe. The defaults are 100 ticks for a cold pulse, well above the roughly 91 µs minimum, and 10 ticks for a warm pulse, well above the 500 ns minimum. The sequencer keeps ownership of the power-good level. The block only overrides it to low while a cold pulse runs. A cold request that arrives while power-good is already low is dropped. Any request that arrives while a pulse is running is also dropped.

Top module: `reset_pulse_gen`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `init_req_n` is 1, and `pwrok_out` equals `pwrok_in`.
- R2: A strobe with `req_cold`=1, sampled while idle and while `pwrok_in`=1, does three things. From the next cycle, `pwrok_out` is held at 0 and `busy` is 1. The low level lasts for exactly COLD_TICKS cycles on which `tick_us` is 1. After that, `pwrok_out` follows `pwrok_in` again.
- R3: A cold strobe sampled while `pwrok_in`=0 is ignored: `busy` stays 0 and `init_req_n` stays 1.
- R4: A strobe with `req_cold`=0, sampled while idle, drives `init_req_n` to 0 from the next cycle. It stays 0 for exactly WARM_TICKS cycles with `tick_us`=1 and then returns to 1. The level of `pwrok_in` has no effect on this.
- R5: During a warm pulse, `pwrok_out` equals `pwrok_in` on every cycle.
- R6: A strobe sampled while `busy`=1 is ignored. The running pulse keeps its kind and its length.
- R7: `busy` is 1 exactly while a pulse output is active. It falls on the same edge as that output is released.
- R8: Cycles with `tick_us`=0 do not advance a pulse. A pulse with no ticks stays active indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | One-cycle request |
| req_cold | input | 1 | 1 = cold request, 0 = warm request |
| pwrok_in | input | 1 | Power-good level from the sequencer |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| pwrok_out | output | 1 | Power-good to the platform controller, with override applied |
| init_req_n | output | 1 | Active-low CPU init request |
| busy | output | 1 | A pulse is in progress |

## Verification
A wrong internal state shows at the ports on the cycle after the request. If a bad gate lets a pulse start, `busy` rises when it should stay low. If a pulse starts as the wrong kind, the wrong output drops. A miscounted timer only shows when the pulse ends, so the bench counts the tick cycles during which each output is low and compares them with the exact parameter value. Dropped requests and stalled ticks are checked by watching that the running pulse keeps its output and its length.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_COLD = 2'd1,
        PG_WARM = 2'd2
    } pulse_kind_t;

    typedef struct packed {
        logic strobe;
        logic cold;
    } pulse_req_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/rpg_timer.sv
module rpg_timer #(
    parameter int unsigned CNT_W = 8,
    parameter int unsigned MAX_V = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = tick && (cnt_q == CNT_W'(1));

    // R2 / R4: the remaining count never exceeds the longest programmed width
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_V));

    // R8: with no tick the counter holds its value
    assert_cnt_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/rpg_ctrl.sv
module rpg_ctrl
    import rpg_pkg::*;
#(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned COLD_TICKS = 100,
    parameter int unsigned WARM_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  pulse_req_t       req,
    input  logic             pwrok_in,
    input  logic             expire,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output pulse_kind_t      kind
);
    pulse_kind_t kind_q, kind_d;

    always_comb begin
        kind_d   = kind_q;
        load     = 1'b0;
        load_val = CNT_W'(WARM_TICKS);
        unique case (kind_q)
            PG_IDLE: begin
                if (req.strobe) begin
                    if (req.cold) begin
                        if (pwrok_in) begin
                            kind_d   = PG_COLD;
                            load     = 1'b1;
                            load_val = CNT_W'(COLD_TICKS);
                        end
                    end else begin
                        kind_d = PG_WARM;
                        load   = 1'b1;
                    end
                end
            end
            PG_COLD, PG_WARM: if (expire) kind_d = PG_IDLE;
            default: kind_d = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) kind_q <= PG_IDLE;
        else     kind_q <= kind_d;
    end

    assign kind = kind_q;

    // R3: a cold strobe with power-good low leaves the block idle
    assert_cold_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (kind_q == PG_IDLE && req.strobe && req.cold && !pwrok_in) |=> kind_q == PG_IDLE);

    // R6: a running pulse keeps its kind until the timer expires
    assert_keep_kind_R6: assert property (@(posedge clk) disable iff (rst)
        (kind_q != PG_IDLE && !expire) |=> $stable(kind_q));

    // R2 / R4: an expiring pulse returns to idle
    assert_end_R7: assert property (@(posedge clk) disable iff (rst)
        (kind_q != PG_IDLE && expire) |=> kind_q == PG_IDLE);
endmodule

// File: rtl/reset_pulse_gen.sv
module reset_pulse_gen
    import rpg_pkg::*;
#(
    parameter int unsigned COLD_TICKS = 100,
    parameter int unsigned WARM_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic req_strobe,
    input  logic req_cold,
    input  logic pwrok_in,
    input  logic tick_us,
    output logic pwrok_out,
    output logic init_req_n,
    output logic busy
);
    localparam int unsigned MAX_T = max_u(COLD_TICKS, WARM_TICKS);
    localparam int unsigned CNT_W = cnt_bits(MAX_T);

    pulse_req_t       req;
    pulse_kind_t      kind;
    logic             load, expire;
    logic [CNT_W-1:0] load_val;

    assign req.strobe = req_strobe;
    assign req.cold   = req_cold;

    rpg_ctrl #(
        .CNT_W(CNT_W), .COLD_TICKS(COLD_TICKS), .WARM_TICKS(WARM_TICKS)
    ) ctrl_i (
        .clk(clk), .rst(rst), .req(req), .pwrok_in(pwrok_in),
        .expire(expire), .load(load), .load_val(load_val), .kind(kind)
    );

    rpg_timer #(.CNT_W(CNT_W), .MAX_V(MAX_T)) timer_i (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .tick(tick_us), .expire(expire)
    );

    assign pwrok_out  = pwrok_in && (kind != PG_COLD);
    assign init_req_n = (kind != PG_WARM);
    assign busy       = (kind != PG_IDLE);

    // R5: a warm pulse passes power-good through untouched
    assert_warm_pwrok_R5: assert property (@(posedge clk) disable iff (rst)
        !init_req_n |-> pwrok_out == pwrok_in);

    // R7: some pulse output is active whenever busy is set
    assert_busy_active_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!init_req_n || !pwrok_out));

    // R8: busy cannot drop on a cycle without a tick
    assert_no_tick_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_us) |=> busy);

    // R3: a cold strobe with power-good low never starts a pulse
    assert_cold_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_strobe && req_cold && !pwrok_in) |=> !busy);
endmodule

// File: tb/reset_pulse_gen_tb_top.sv
module reset_pulse_gen_tb_top;
    localparam int unsigned COLD_T = 100;
    localparam int unsigned WARM_T = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_strobe = 1'b0, req_cold = 1'b0, pwrok_in = 1'b1, tick_us = 1'b0;
    logic pwrok_out, init_req_n, busy;

    int n_chk = 0, n_fail = 0;
    int cold_cnt = 0, warm_cnt = 0, r5_bad = 0;
    bit tick_en = 1'b1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reset_pulse_gen #(.COLD_TICKS(COLD_T), .WARM_TICKS(WARM_T)) dut_i (
        .clk(clk), .rst(rst), .req_strobe(req_strobe), .req_cold(req_cold),
        .pwrok_in(pwrok_in), .tick_us(tick_us), .pwrok_out(pwrok_out),
        .init_req_n(init_req_n), .busy(busy)
    );

    // tick every 4th cycle
    initial begin
        int unsigned ph = 0;
        forever begin
            @(posedge clk); #1;
            tick_us = tick_en && (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    // output monitors, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (tick_us && !pwrok_out && pwrok_in) cold_cnt++;
            if (tick_us && !init_req_n) warm_cnt++;
            if (!init_req_n && pwrok_out !== pwrok_in) r5_bad++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic request(input logic cold);
        @(posedge clk); #1;
        req_strobe = 1'b1; req_cold = cold;
        @(posedge clk); #1;
        req_strobe = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // vector: {cold, pwrok level, expect start}
    localparam logic [2:0] VEC [4] = '{3'b111, 3'b100, 3'b011, 3'b001};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 init_req_n after reset", init_req_n, 1);
        check("R1 pwrok_out follows", pwrok_out, 1);
        pwrok_in = 1'b0;
        @(negedge clk);
        check("R1 pwrok_out follows low", pwrok_out, 0);

        foreach (VEC[v]) begin
            logic c, p, s;
            {c, p, s} = VEC[v];
            pwrok_in = p;
            cold_cnt = 0; warm_cnt = 0; r5_bad = 0;
            request(c);
            @(negedge clk);
            check(c ? (s ? "R2 cold start busy" : "R3 cold ignored busy") : "R4 warm start busy", busy, s);
            if (c && s) check("R2 pwrok held low", pwrok_out, 0);
            if (!c)     check("R4 init low", init_req_n, 0);
            if (c && !s) check("R3 init untouched", init_req_n, 1);
            wait_idle();
            check("R7 busy released", busy, 0);
            if (c) check("R2 cold length in ticks", cold_cnt, s ? COLD_T : 0);
            else   check("R4 warm length in ticks", warm_cnt, WARM_T);
            if (!c) check("R5 pwrok during warm", r5_bad, 0);
            check("R2 R4 outputs restored", {pwrok_out, init_req_n}, {p, 1'b1});
        end

        // R6: cold request during warm pulse is ignored
        pwrok_in = 1'b1; cold_cnt = 0; warm_cnt = 0;
        request(1'b0);
        repeat (5) @(negedge clk);
        request(1'b1);
        @(negedge clk);
        check("R6 pwrok not dropped", pwrok_out, 1);
        wait_idle();
        check("R6 warm length kept", warm_cnt, WARM_T);
        check("R6 no cold pulse", cold_cnt, 0);

        // R6: warm request during cold pulse is ignored
        cold_cnt = 0; warm_cnt = 0;
        request(1'b1);
        repeat (20) @(negedge clk);
        request(1'b0);
        @(negedge clk);
        check("R6 init untouched in cold", init_req_n, 1);
        wait_idle();
        check("R6 cold length kept", cold_cnt, COLD_T);
        check("R6 no warm pulse", warm_cnt, 0);

        // R8: stalled ticks keep the pulse active
        warm_cnt = 0;
        request(1'b0);
        repeat (6) @(negedge clk);
        tick_en = 1'b0;
        repeat (60) @(negedge clk);
        check("R8 busy while stalled", busy, 1);
        check("R8 init low while stalled", init_req_n, 0);
        tick_en = 1'b1;
        wait_idle();
        check("R8 warm length after stall", warm_cnt, WARM_T);

        // R5: sequencer toggles power-good during a warm pulse
        r5_bad = 0; warm_cnt = 0;
        request(1'b0);
        @(negedge clk); pwrok_in = 1'b0;
        repeat (3) @(negedge clk); pwrok_in = 1'b1;
        wait_idle();
        check("R5 pwrok passthrough under toggle", r5_bad, 0);

        // R1: reset mid-pulse returns to idle
        request(1'b1);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after mid-pulse reset", {busy, init_req_n, pwrok_out}, 3'b011);

        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule